// File: doc/BRIEF.md
# Vectored Interrupt Controller with Deglitched External Input

This block gathers up to ten interrupt sources for a small 8-bit processor core and turns them into one request line and a fixed vector address. Source 0 is an external pin. Sources 1 to 9 are one-cycle pulses from on-chip peripherals: a port pin-change detector, timer overflows, conversion done, comparator change and the two underflows of a pulse generator. Each source has a latched flag and an enable bit in a mask register. A global enable gates all requests. Commands from the core set and clear the global enable. When the core accepts an interrupt, the global enable is cleared.

The external pin is first synchronised. A minimum-width filter then rejects any level that does not hold for a set number of clocks. A bypass input skips this filter for slow-clock operation. A select input picks the rising or the falling edge of the filtered level as the event that sets flag 0. The processor pipeline, its return stack and sleep wake-up are outside the block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While a request is raised, the vector is 3 + 3*i, where i is the lowest-numbered source whose flag and mask bit are both 1. Source 0 gives 003h and source 9 gives 01Eh.
- R2: When no flag is both set and unmasked, or when the global enable is 0, `irq_req` is 0 and `irq_vector` is 0.
- R3: A flag write (`flag_wr_en`) clears each flag whose `flag_wr_data` bit is 0 and leaves the other flags unchanged. A flag that is 0 is never set by a write.
- R4: A hardware event that reaches a flag in the same cycle as a software clear of that flag leaves the flag at 1.
- R5: A source whose mask bit is 0 still latches its flag but does not raise a request. Mask bit i is bit i of `mask_wr_data`, and 1 means enabled.
- R6: `cmd_eni` and `cmd_reti` set the global enable on the next clock, and `cmd_disi` clears it. If a set command and a clear come together, the clear wins.
- R7: When `irq_take` is high while `irq_req` is high, the global enable is 0 after that clock edge, and `irq_req` is 0 one cycle later.
- R8: With the filter in use, a level on `ext_irq_pin` that lasts fewer than 8 clocks is discarded. A level that lasts 8 clocks or more is accepted.
- R9: With `filt_bypass` at 1, the filter is skipped, and a pin pulse one clock wide sets flag 0.
- R10: With `edge_fall` at 0 only a rising edge of the accepted level sets flag 0; with 1 only a falling edge does.
- R11: Under reset, all flags, the mask, the global enable, `irq_req` and `irq_vector` are 0.
- R12: `irq_req` and `irq_vector` are registered. They follow the flag, mask and global-enable state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_pin | input | 1 | Asynchronous external interrupt pin (source 0) |
| filt_bypass | input | 1 | 1 skips the minimum-width filter |
| edge_fall | input | 1 | 0 selects the rising edge, 1 the falling edge |
| periph_evt | input | NUM_SRC-1 | One-cycle event pulses; bit k sets the flag of source k+1 |
| flag_wr_en | input | 1 | Flag write strobe (clear-only) |
| flag_wr_data | input | NUM_SRC | Write data; a 0 bit clears that flag |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | NUM_SRC | New mask value, 1 = source enabled |
| cmd_eni | input | 1 | Enable-interrupts command |
| cmd_disi | input | 1 | Disable-interrupts command |
| cmd_reti | input | 1 | Return-from-interrupt command, sets global enable |
| irq_take | input | 1 | The core accepts the pending request |
| flags | output | NUM_SRC | Current flag register |
| gie | output | 1 | Global interrupt enable |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | VEC_W | Registered vector word address, 0 when idle |

## Verification
The hardest case to produce is the boundary of the external filter. A pin pulse of exactly seven clocks must disappear and one of exactly eight must be accepted. This depends on the two synchroniser stages and the run counter lining up. The bench drives the pin on falling clock edges for an exact number of rising edges, and then waits well past the filter latency before it reads flag 0. A second case that is hard to reach is a flag set that collides with a clear. It is reached by pulsing a peripheral event in the same cycle as a write of all zeros.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_SET  = 2'd1,
    GIE_CLR  = 2'd2
  } gie_op_e;

  function automatic gie_op_e gie_decode(input logic set_cmd, input logic clr_cmd);
    if (clr_cmd)      return GIE_CLR;
    else if (set_cmd) return GIE_SET;
    else              return GIE_HOLD;
  endfunction

endpackage

// File: rtl/irqv_edge_filter.sv
module irqv_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic bypass_i,
  input  logic fall_i,
  output logic edge_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sample;
  logic                   filt_q;
  logic [CW-1:0]          run_q;
  logic                   lvl;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign sample = sync_q[SYNC_STAGES-1];

  // Accept a new level only after it has been seen for FILT_LEN samples in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sample != filt_q) begin
      if (run_q == CNT_LAST) begin
        filt_q <= sample;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign lvl = bypass_i ? sample : filt_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign edge_o = fall_i ? (prev_q & ~lvl) : (lvl & ~prev_q);

endmodule

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic sw_clr;
      assign sw_clr = wr_en & ~wr_data[i];
      always_ff @(posedge clk) begin
        if (rst) flag_q[i] <= 1'b0;
        else     flag_q[i] <= set_i[i] | (flag_q[i] & ~sw_clr);
      end
    end
  endgenerate

  assign flag_o = flag_q;

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int NUM_SRC    = 10,
  parameter int VEC_W      = 11,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 3
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] idx;

  // Scan downward so the lowest-numbered pending source is left in idx
  always_comb begin
    any_o = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign vec_o = any_o ? (VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE)) : '0;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC     = 10,
  parameter int VEC_W       = 11,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_irq_pin,
  input  logic               filt_bypass,
  input  logic               edge_fall,
  input  logic [NUM_SRC-2:0] periph_evt,
  input  logic               flag_wr_en,
  input  logic [NUM_SRC-1:0] flag_wr_data,
  input  logic               mask_wr_en,
  input  logic [NUM_SRC-1:0] mask_wr_data,
  input  logic               cmd_eni,
  input  logic               cmd_disi,
  input  logic               cmd_reti,
  input  logic               irq_take,
  output logic [NUM_SRC-1:0] flags,
  output logic               gie,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vector
);
  import irqv_pkg::*;

  logic               ext_edge;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] mask_q;
  logic               gie_q;
  logic               any_pend;
  logic [VEC_W-1:0]   vec_next;
  logic               req_q;
  logic [VEC_W-1:0]   vec_q;
  gie_op_e            gie_op;

  irqv_edge_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (ext_irq_pin),
    .bypass_i(filt_bypass),
    .fall_i  (edge_fall),
    .edge_o  (ext_edge)
  );

  assign set_vec = {periph_evt, ext_edge};

  irqv_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .wr_en  (flag_wr_en),
    .wr_data(flag_wr_data),
    .flag_o (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)             mask_q <= '0;
    else if (mask_wr_en) mask_q <= mask_wr_data;
  end

  assign gie_op = gie_decode(cmd_eni | cmd_reti, cmd_disi | (irq_take & req_q));

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else begin
      case (gie_op)
        GIE_SET: gie_q <= 1'b1;
        GIE_CLR: gie_q <= 1'b0;
        default: gie_q <= gie_q;
      endcase
    end
  end

  irqv_prio #(
    .NUM_SRC   (NUM_SRC),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) u_prio (
    .pend_i(flags & mask_q),
    .any_o (any_pend),
    .vec_o (vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= gie_q & any_pend;
      vec_q <= (gie_q & any_pend) ? vec_next : '0;
    end
  end

  assign gie        = gie_q;
  assign irq_req    = req_q;
  assign irq_vector = vec_q;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_SRC    = 10,
  parameter int VEC_W      = 11,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-2:0] periph_evt,
  input logic               irq_take,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               gie,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vector
);
  int vec_i;
  assign vec_i = int'(irq_vector);

  AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (vec_i >= VEC_BASE) && (((vec_i - VEC_BASE) % VEC_STRIDE) == 0)
                && (vec_i < VEC_BASE + NUM_SRC * VEC_STRIDE)); // R1

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vector == '0)); // R2

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags[NUM_SRC-1:1] & ~$past(flags[NUM_SRC-1:1]) & ~$past(periph_evt)) == '0)); // R3

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (periph_evt != '0) |=> ((flags[NUM_SRC-1:1] & $past(periph_evt)) == $past(periph_evt))); // R4

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(flags & mask_q) != '0)); // R5

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie)); // R12

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_req) |=> !gie); // R7

endmodule

bind irq_vector_ctrl irqv_checker #(
  .NUM_SRC   (NUM_SRC),
  .VEC_W     (VEC_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE)
) u_irqv_checker (
  .clk       (clk),
  .rst       (rst),
  .periph_evt(periph_evt),
  .irq_take  (irq_take),
  .flags     (flags),
  .mask_q    (mask_q),
  .gie       (gie),
  .irq_req   (irq_req),
  .irq_vector(irq_vector)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int N  = 10;
  localparam int VW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_irq_pin = 1'b0;
  logic          filt_bypass = 1'b0;
  logic          edge_fall = 1'b0;
  logic [N-2:0]  periph_evt = '0;
  logic          flag_wr_en = 1'b0;
  logic [N-1:0]  flag_wr_data = '0;
  logic          mask_wr_en = 1'b0;
  logic [N-1:0]  mask_wr_data = '0;
  logic          cmd_eni = 1'b0;
  logic          cmd_disi = 1'b0;
  logic          cmd_reti = 1'b0;
  logic          irq_take = 1'b0;
  logic [N-1:0]  flags;
  logic          gie;
  logic          irq_req;
  logic [VW-1:0] irq_vector;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .ext_irq_pin(ext_irq_pin), .filt_bypass(filt_bypass),
    .edge_fall(edge_fall), .periph_evt(periph_evt), .flag_wr_en(flag_wr_en),
    .flag_wr_data(flag_wr_data), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cmd_eni(cmd_eni), .cmd_disi(cmd_disi), .cmd_reti(cmd_reti), .irq_take(irq_take),
    .flags(flags), .gie(gie), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // Row layout: {gie, periph_evt[8:0], mask[9:0], exp_req, exp_vec[7:0]}
  localparam logic [28:0] TBL [0:6] = '{
    {1'b1, 9'b000000001, 10'h3FF, 1'b1, 8'h06},
    {1'b1, 9'b100000000, 10'h3FF, 1'b1, 8'h1E},
    {1'b1, 9'b000110000, 10'h3FF, 1'b1, 8'h12},
    {1'b1, 9'b111111111, 10'h200, 1'b1, 8'h1E},
    {1'b1, 9'b000000110, 10'h000, 1'b0, 8'h00},
    {1'b1, 9'b010000010, 10'h104, 1'b1, 8'h09},
    {1'b0, 9'b000001000, 10'h3FF, 1'b0, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_wr_en = 1'b1; flag_wr_data = '0; tick(1);
    flag_wr_en = 1'b0; flag_wr_data = '0;
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    mask_wr_en = 1'b1; mask_wr_data = m; tick(1);
    mask_wr_en = 1'b0;
  endtask

  task automatic set_gie(input logic on);
    if (on) cmd_eni = 1'b1; else cmd_disi = 1'b1;
    tick(1);
    cmd_eni = 1'b0; cmd_disi = 1'b0;
  endtask

  task automatic pin_pulse(input logic lvl, input int w);
    ext_irq_pin = lvl; tick(w); ext_irq_pin = ~lvl;
  endtask

  initial begin
    #800us;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R11: reset state
    chk("R11 flags", 32'(flags), 0);
    chk("R11 gie", 32'(gie), 0);
    chk("R11 req", 32'(irq_req), 0);
    chk("R11 vec", 32'(irq_vector), 0);

    // Table walk: R1, R2, R5
    for (int r = 0; r < 7; r++) begin
      set_gie(TBL[r][28]);
      set_mask(TBL[r][18:9]);
      clear_flags();
      periph_evt = TBL[r][27:19]; tick(1); periph_evt = '0;
      tick(2);
      chk($sformatf("R5 row%0d flags latched", r), 32'(flags), 32'({TBL[r][27:19], 1'b0}));
      chk($sformatf("R1/R2 row%0d req", r), 32'(irq_req), 32'(TBL[r][8]));
      chk($sformatf("R1/R2 row%0d vec", r), 32'(irq_vector), 32'(TBL[r][7:0]));
    end

    // R3: writes never set, only clear
    set_gie(1'b0);
    clear_flags();
    flag_wr_en = 1'b1; flag_wr_data = '1; tick(1); flag_wr_en = 1'b0;
    tick(1);
    chk("R3 write ones to empty flags", 32'(flags), 0);
    periph_evt = 9'b000101000; tick(1); periph_evt = '0;
    flag_wr_en = 1'b1; flag_wr_data = ~(10'b1 << 4); tick(1); flag_wr_en = 1'b0;
    tick(1);
    chk("R3 selective clear", 32'(flags), 32'(10'b1 << 6));

    // R4: set collides with clear
    clear_flags();
    periph_evt = 9'b000000001; flag_wr_en = 1'b1; flag_wr_data = '0; tick(1);
    periph_evt = '0; flag_wr_en = 1'b0;
    tick(1);
    chk("R4 set wins over clear", 32'(flags), 32'h2);

    // R12 latency, R7 take, R6 commands
    clear_flags();
    set_mask('1);
    set_gie(1'b1);
    periph_evt = 9'b000000100; tick(1); periph_evt = '0;
    chk("R12 req not yet", 32'(irq_req), 0);
    tick(1);
    chk("R12 req one cycle later", 32'(irq_req), 1);
    chk("R1 vec src3", 32'(irq_vector), 32'h0C);
    irq_take = 1'b1; tick(1); irq_take = 1'b0;
    chk("R7 gie cleared by take", 32'(gie), 0);
    tick(1);
    chk("R7 req dropped", 32'(irq_req), 0);
    cmd_reti = 1'b1; tick(1); cmd_reti = 1'b0;
    chk("R6 reti sets gie", 32'(gie), 1);
    tick(1);
    chk("R6 req back after reti", 32'(irq_req), 1);
    cmd_eni = 1'b1; cmd_disi = 1'b1; tick(1); cmd_eni = 1'b0; cmd_disi = 1'b0;
    chk("R6 clear wins over set", 32'(gie), 0);

    // R8: filter width boundary, rising edge
    filt_bypass = 1'b0; edge_fall = 1'b0;
    clear_flags();
    pin_pulse(1'b1, 7); tick(25);
    chk("R8 7-clock pulse rejected", 32'(flags[0]), 0);
    pin_pulse(1'b1, 8); tick(25);
    chk("R8 8-clock pulse accepted", 32'(flags[0]), 1);
    set_gie(1'b1);
    periph_evt = '1; tick(1); periph_evt = '0;
    tick(2);
    chk("R1 pin source wins", 32'(irq_vector), 32'h03);
    set_gie(1'b0);

    // R10: falling edge select
    edge_fall = 1'b1;
    clear_flags();
    ext_irq_pin = 1'b1; tick(25);
    chk("R10 rising ignored when falling selected", 32'(flags[0]), 0);
    ext_irq_pin = 1'b0; tick(25);
    chk("R10 falling edge sets flag", 32'(flags[0]), 1);

    // R9: bypass accepts a one-clock pulse
    edge_fall = 1'b0; filt_bypass = 1'b1;
    clear_flags();
    pin_pulse(1'b1, 1); tick(10);
    chk("R9 bypass one-clock pulse", 32'(flags[0]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule